// File: doc/BRIEF.md
# Dual-Mode Serial Converter Output Port

This block is the digital serial side of a 10-bit successive-approximation converter. A host drives a serial clock, an active-low chip select and a frame sync line. The port returns each result as a 16-bit word on a single data line: six zero bits, then the 10-bit result with the most significant bit first. The result itself comes from a behavioural conversion stub on a parallel input. The port also reports three status flags: input sampling, conversion in progress, and powered down. It also drives an enable for the data line, so that a pad can three-state it.

When chip select falls, frame sync is read twice. If both reads are high, the port works as a three-wire microcontroller slave. In that mode the serial clock alone paces the frames, and data changes on the rising edge. Any other pair of reads selects DSP mode. In DSP mode the host frames each word with frame sync, and a high frame sync can restart a frame at any bit. In both modes the port powers itself down after the last bit. All inputs are sampled by a fast system clock. Each serial-clock edge is detected as a one-cycle event, and the outputs change on the system clock edge at which a new input level is first seen.

Top module: `sadc_serial_port`

## Requirements
- R1: While chip select is high, the port is off: dout_oe=0, powered_down=1, sampling=0, converting=0 and dout=0, from the system clock edge after chip select is seen high.
- R2: Frame sync is captured on the cycle in which chip select is first seen low, and again on the next cycle. Microcontroller mode (powered_down=0, dout_oe=1 once resolved) is chosen only when both captures are 1. Any other pair selects DSP mode.
- R3: A frame is 16 bit positions. Position k is driven at the k-th serial-clock rising edge of the frame. Positions 1 to 6 are 0, and positions 7 to 16 carry result bits 9 down to 0. Outside positions 7 to 16, dout is 0.
- R4: In DSP mode, once the mode is resolved, dout_oe=1 and powered_down=1 until a serial-clock falling edge sees frame sync high.
- R5: In DSP mode, a frame starts at the first falling edge that sees frame sync low after it was seen high. sampling is 1 from that edge until rising edge 6. converting is 1 from rising edge 6 until rising edge 16.
- R6: In DSP mode, the 17th falling edge of a frame sets powered_down=1, and the 17th rising edge clears dout_oe. A falling edge that then sees frame sync high sets dout_oe=1 and powered_down=0.
- R7: In DSP mode, a falling edge that sees frame sync high at any point aborts the frame (sampling=0, converting=0, powered_down=0). This includes the 17th falling edge, so a new frame can follow at once without a powerdown.
- R8: In microcontroller mode, rising edge 1 after the mode is resolved starts sampling. The flag windows are the same as in R5, counted on rising edges. Falling edge 16 sets powered_down=1, and rising edge 17 starts the next frame at position 1. Frame sync has no effect in this mode.
- R9: In microcontroller mode, raising chip select before the last bit ends the frame. The next chip-select fall starts a full new frame from position 1.
- R10: The result is taken from the parallel input at rising edge 6 of the frame. Changes to that input later in the frame do not alter the bits sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples every other input |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Active-low chip select |
| fs | input | 1 | Frame sync, and the mode strap when chip select falls |
| sclk | input | 1 | Serial clock from the host |
| conv_result | input | RES_W | Parallel result from the conversion stub |
| dout | output | 1 | Serial data line value |
| dout_oe | output | 1 | Output enable for the data line (0 means three-state) |
| sampling | output | 1 | Sample window open |
| converting | output | 1 | Conversion window open |
| powered_down | output | 1 | Port in full or auto powerdown |

## Verification
The bench targets the following corner cases:
- Split mode strap: frame sync disagrees between its two captures, in either order. A port that trusted only one capture would come up in microcontroller mode and leave powerdown early.
- Frame sync high on the 17th falling edge: a design that ignored it there would power down and three-state the line between back-to-back frames.
- Frame sync high mid-word: a design that ignored it would keep shifting the old word.
- Parallel result changed after the sample window: a design that read the input live would corrupt the low bits.
- Microcontroller mode: frame sync toggling, wake on rising edge 17, and an early chip-select rise. These expose a port that listens to frame sync in that mode or fails to restart.

// File: rtl/sadc_pkg.sv
`timescale 1ns/1ps
// Shared types for the serial converter port.
// Assumes: nothing; holds only the frame phase encoding.
package sadc_pkg;
    typedef enum logic [3:0] {
        PH_OFF,     // chip select high
        PH_MODE,    // second mode capture pending
        PH_DWAIT,   // DSP mode, awaiting first frame sync
        PH_ARMED,   // DSP mode, frame sync seen high
        PH_RUN,     // frame in progress
        PH_TAIL,    // DSP mode, auto powerdown, line still driven
        PH_SLEEP,   // DSP mode, auto powerdown, line three-stated
        PH_UIDLE,   // micro mode, awaiting first rising edge
        PH_UDONE    // micro mode, auto powerdown after bit 16
    } phase_e;
endpackage

// File: rtl/sadc_edge.sv
`timescale 1ns/1ps
// Edge detector: flags rising and falling transitions of a level
// sampled by clk. Assumes sig is already synchronous to clk.
module sadc_edge #(
    parameter logic INIT = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sig,
    output logic rise,
    output logic fall
);
    logic prev_q;

    // Remember the level from the previous system clock.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= INIT;
        else        prev_q <= sig;
    end

    assign rise = sig & ~prev_q;
    assign fall = ~sig & prev_q;
endmodule

// File: rtl/sadc_mode_sel.sv
`timescale 1ns/1ps
// Mode selector: captures frame sync on the chip-select fall and one
// cycle later. Micro mode only if both captures are high.
// Assumes cs_fall is a one-cycle pulse from the edge detector.
module sadc_mode_sel (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic cs_fall,
    input  logic fs,
    output logic mode_uc
);
    logic pend_q;
    logic first_q;
    logic uc_q;

    // Track the delayed second capture after a chip-select fall.
    always_ff @(posedge clk) begin
        if (!rst_n || cs_n) pend_q <= 1'b0;
        else                pend_q <= cs_fall;
    end

    // First capture of frame sync at the chip-select fall.
    always_ff @(posedge clk) begin
        if (!rst_n)       first_q <= 1'b0;
        else if (cs_fall) first_q <= fs;
    end

    // Resolve and hold the mode on the second capture.
    always_ff @(posedge clk) begin
        if (!rst_n)      uc_q <= 1'b0;
        else if (pend_q) uc_q <= first_q & fs;
    end

    assign mode_uc = pend_q ? (first_q & fs) : uc_q;

    // R2: a low second capture always yields DSP mode
    p_low_second_dsp_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q && !fs) |=> !uc_q);
    // R2: the second capture is taken exactly once
    p_pend_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        pend_q |=> !pend_q);
endmodule

// File: rtl/sadc_frame_seq.sv
`timescale 1ns/1ps
// Frame sequencer: owns the phase and the rising-edge bit count of a
// frame, for both DSP and micro modes. Assumes serial-clock edges
// arrive as one-cycle pulses and never in the same cycle.
module sadc_frame_seq
    import sadc_pkg::*;
#(
    parameter int LEAD_ZEROS = 6,
    parameter int FRAME_LEN  = 16,
    parameter int CNT_W      = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_n,
    input  logic             cs_fall,
    input  logic             mode_uc,
    input  logic             fs,
    input  logic             s_rise,
    input  logic             s_fall,
    output phase_e           phase,
    output logic [CNT_W-1:0] cnt,
    output logic             load
);
    localparam logic [CNT_W-1:0] LAST     = CNT_W'(FRAME_LEN);
    localparam logic [CNT_W-1:0] PRE_LOAD = CNT_W'(LEAD_ZEROS - 1);
    localparam logic [CNT_W-1:0] ONE      = CNT_W'(1);

    phase_e           ph_n;
    logic [CNT_W-1:0] cnt_n;
    logic             active;

    assign active = !cs_n && !cs_fall;

    // Next phase and count from the current serial events.
    always_comb begin
        ph_n  = phase;
        cnt_n = cnt;
        if (cs_n) begin
            ph_n  = PH_OFF;
            cnt_n = '0;
        end else if (cs_fall) begin
            ph_n  = PH_MODE;
            cnt_n = '0;
        end else begin
            case (phase)
                PH_MODE:  ph_n = mode_uc ? PH_UIDLE : PH_DWAIT;
                PH_DWAIT, PH_SLEEP: begin
                    if (s_fall && fs) ph_n = PH_ARMED;
                end
                PH_ARMED: begin
                    if (s_fall && !fs) begin
                        ph_n  = PH_RUN;
                        cnt_n = '0;
                    end
                end
                PH_RUN: begin
                    if (!mode_uc && s_fall && fs) begin
                        ph_n  = PH_ARMED;
                        cnt_n = '0;
                    end else if (s_rise && cnt != LAST) begin
                        cnt_n = cnt + ONE;
                    end else if (s_fall && cnt == LAST) begin
                        ph_n = mode_uc ? PH_UDONE : PH_TAIL;
                    end
                end
                PH_TAIL: begin
                    if (s_fall && fs) begin
                        ph_n  = PH_ARMED;
                        cnt_n = '0;
                    end else if (s_rise) begin
                        ph_n  = PH_SLEEP;
                        cnt_n = '0;
                    end
                end
                PH_UIDLE, PH_UDONE: begin
                    if (s_rise) begin
                        ph_n  = PH_RUN;
                        cnt_n = ONE;
                    end
                end
                default: ph_n = PH_OFF;
            endcase
        end
    end

    // Register the phase and bit count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_OFF;
            cnt   <= '0;
        end else begin
            phase <= ph_n;
            cnt   <= cnt_n;
        end
    end

    // Result capture strobe at the rising edge that closes sampling.
    assign load = active && (phase == PH_RUN) && s_rise && (cnt == PRE_LOAD);

    // R3: the bit count never passes the frame length
    p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST);
    // R8: a rising edge in micro powerdown starts position 1
    p_uc_wake_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (active && phase == PH_UDONE && s_rise) |=> (phase == PH_RUN && cnt == ONE));
    // R7: frame sync high at a DSP falling edge re-arms the port
    p_dsp_rearm_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !mode_uc && s_fall && fs &&
         (phase == PH_RUN || phase == PH_TAIL)) |=> (phase == PH_ARMED && cnt == '0));
endmodule

// File: rtl/sadc_result_reg.sv
`timescale 1ns/1ps
// Result register: holds the conversion result captured when the
// sample window closes, and picks the bit for the current position.
// Assumes cnt counts rising edges 1..FRAME_LEN within a frame.
module sadc_result_reg #(
    parameter int RES_W      = 10,
    parameter int LEAD_ZEROS = 6,
    parameter int CNT_W      = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [RES_W-1:0] conv_result,
    input  logic             show,
    input  logic [CNT_W-1:0] cnt,
    output logic             dout_bit
);
    localparam int FRAME_LEN = RES_W + LEAD_ZEROS;
    localparam int SEL_W     = (RES_W > 1) ? $clog2(RES_W) : 1;

    logic [RES_W-1:0] res_q;
    logic [SEL_W-1:0] sel;
    logic             in_data;

    // Capture the stub result at the end of the sample window.
    always_ff @(posedge clk) begin
        if (!rst_n)    res_q <= '0;
        else if (load) res_q <= conv_result;
    end

    assign in_data  = show && (cnt > CNT_W'(LEAD_ZEROS));
    assign sel      = SEL_W'(FRAME_LEN - int'(cnt));
    assign dout_bit = in_data ? res_q[sel] : 1'b0;

    // R10: the captured result is held between loads
    p_hold_result_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(res_q));
endmodule

// File: rtl/sadc_serial_port.sv
`timescale 1ns/1ps
// Dual-mode serial output port of a 10-bit converter. Samples the host
// serial clock, chip select and frame sync on clk, selects DSP or
// micro mode at the chip-select fall, sequences sample, convert and
// shift-out windows, and controls auto powerdown and three-state.
// Assumes the host serial clock is well below half the clk rate.
module sadc_serial_port
    import sadc_pkg::*;
#(
    parameter int RES_W      = 10,
    parameter int LEAD_ZEROS = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_n,
    input  logic             fs,
    input  logic             sclk,
    input  logic [RES_W-1:0] conv_result,
    output logic             dout,
    output logic             dout_oe,
    output logic             sampling,
    output logic             converting,
    output logic             powered_down
);
    localparam int FRAME_LEN = RES_W + LEAD_ZEROS;
    localparam int CNT_W     = $clog2(FRAME_LEN + 1);

    logic             s_rise, s_fall;
    logic             cs_rise, cs_fall;
    logic             mode_uc;
    phase_e           phase;
    logic [CNT_W-1:0] cnt;
    logic             load;
    logic             show;

    sadc_edge #(.INIT(1'b0)) u_sclk_edge (
        .clk(clk), .rst_n(rst_n), .sig(sclk), .rise(s_rise), .fall(s_fall)
    );

    sadc_edge #(.INIT(1'b1)) u_cs_edge (
        .clk(clk), .rst_n(rst_n), .sig(cs_n), .rise(cs_rise), .fall(cs_fall)
    );

    sadc_mode_sel u_mode (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .cs_fall(cs_fall),
        .fs(fs), .mode_uc(mode_uc)
    );

    sadc_frame_seq #(
        .LEAD_ZEROS(LEAD_ZEROS), .FRAME_LEN(FRAME_LEN), .CNT_W(CNT_W)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .cs_fall(cs_fall),
        .mode_uc(mode_uc), .fs(fs), .s_rise(s_rise), .s_fall(s_fall),
        .phase(phase), .cnt(cnt), .load(load)
    );

    assign show = (phase == PH_RUN) || (phase == PH_TAIL) || (phase == PH_UDONE);

    sadc_result_reg #(
        .RES_W(RES_W), .LEAD_ZEROS(LEAD_ZEROS), .CNT_W(CNT_W)
    ) u_res (
        .clk(clk), .rst_n(rst_n), .load(load), .conv_result(conv_result),
        .show(show), .cnt(cnt), .dout_bit(dout)
    );

    // Status decode from the registered phase and count.
    assign dout_oe      = !(phase inside {PH_OFF, PH_MODE, PH_SLEEP});
    assign powered_down = phase inside {PH_OFF, PH_MODE, PH_DWAIT, PH_TAIL,
                                        PH_SLEEP, PH_UDONE};
    assign sampling     = (phase == PH_RUN) && (cnt < CNT_W'(LEAD_ZEROS));
    assign converting   = (phase == PH_RUN) && (cnt >= CNT_W'(LEAD_ZEROS))
                          && (cnt < CNT_W'(FRAME_LEN));

    // R1: chip select high turns the port off on the next cycle
    p_cs_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> (!dout_oe && powered_down && !dout));
    // R1: a chip-select rise is followed by three-state
    p_cs_rise_hiz_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cs_rise |=> !dout_oe);
    // R3: the data line carries only zeros while sampling
    p_zero_lead_r3: assert property (@(posedge clk) disable iff (!rst_n)
        sampling |-> !dout);
    // R5: sample and convert windows never overlap
    p_flag_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(sampling && converting));
    // R6: powerdown never coincides with an open window
    p_pd_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        powered_down |-> (!sampling && !converting));
    // R6: a three-stated line implies powerdown
    p_hiz_pd_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !dout_oe |-> powered_down);
endmodule

// File: tb/tb_sadc_serial_port.sv
`timescale 1ns/1ps
module tb_sadc_serial_port;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1;
    logic       fs = 1'b0;
    logic       sclk = 1'b0;
    logic [9:0] conv_result = '0;
    logic       dout, dout_oe, sampling, converting, powered_down;

    int    n_chk = 0;
    int    n_err = 0;
    bit    done = 0;
    bit    cmp_en = 0;
    string cur_req = "R1";

    always #2.5 clk = ~clk;

    sadc_serial_port dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .fs(fs), .sclk(sclk),
        .conv_result(conv_result), .dout(dout), .dout_oe(dout_oe),
        .sampling(sampling), .converting(converting),
        .powered_down(powered_down)
    );

    // Behavioural reference: phase code, edges seen in frame, captured word.
    // 0 off, 1 mode pending, 2 dsp wait, 3 armed, 4 frame, 5 tail,
    // 6 sleep, 7 micro idle, 8 micro done
    int         mph = 0;
    int         medges = 0;
    bit         muc = 0, mfirst = 0;
    logic [9:0] mword = '0;
    logic       psclk = 0, pcs = 1;

    always @(posedge clk) begin
        bit r, f, csf;
        if (!rst_n) begin
            mph = 0; medges = 0; psclk = 0; pcs = 1; mword = '0; muc = 0;
        end else begin
            r = sclk && !psclk;
            f = !sclk && psclk;
            csf = !cs_n && pcs;
            if (cs_n) begin
                mph = 0; medges = 0;
            end else if (csf) begin
                mph = 1; medges = 0; mfirst = fs;
            end else if (mph == 1) begin
                muc = mfirst && fs;
                mph = muc ? 7 : 2;
            end else if ((mph == 2 || mph == 6) && f && fs) begin
                mph = 3;
            end else if (mph == 3 && f && !fs) begin
                mph = 4; medges = 0;
            end else if ((mph == 4 || mph == 5) && !muc && f && fs) begin
                mph = 3; medges = 0;
            end else if (mph == 4 && r && medges < 16) begin
                medges++;
                if (medges == 6) mword = conv_result;
            end else if (mph == 4 && f && medges == 16) begin
                mph = muc ? 8 : 5;
            end else if (mph == 5 && r) begin
                mph = 6; medges = 0;
            end else if ((mph == 7 || mph == 8) && r) begin
                mph = 4; medges = 1;
            end
            psclk = sclk;
            pcs = cs_n;
        end
    end

    task automatic chk(string req, logic [15:0] act, logic [15:0] exp, string what);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
        end
    endtask

    // Per-clock comparison of all outputs against the reference.
    always @(negedge clk) begin
        logic [4:0] e;
        if (cmp_en) begin
            e[4] = (mph == 4 || mph == 5 || mph == 8) && medges >= 7 ? mword[16 - medges] : 1'b0;
            e[3] = !(mph == 0 || mph == 1 || mph == 6);
            e[2] = (mph == 4) && medges < 6;
            e[1] = (mph == 4) && medges >= 6 && medges < 16;
            e[0] = (mph == 0 || mph == 1 || mph == 2 || mph == 5 || mph == 6 || mph == 8);
            chk(cur_req, {11'd0, dout, dout_oe, sampling, converting, powered_down},
                {11'd0, e}, "per-clock {dout,oe,samp,conv,pd}");
        end
    end

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    // One serial clock period; the host reads dout before the fall.
    task automatic sc(output logic b);
        sclk = 1'b1; tick(2); b = dout;
        sclk = 1'b0; tick(2);
    endtask

    task automatic read_bits(int n, inout logic [15:0] w);
        for (int k = 0; k < n; k++) begin
            logic b;
            sc(b);
            w = {w[14:0], b};
        end
    endtask

    task automatic dsp_start();
        logic b;
        fs = 1'b1; sc(b);
        fs = 1'b0; sc(b);
    endtask

    task automatic flags(string req, logic oe, logic pd, logic s, logic c, string what);
        chk(req, {12'd0, dout_oe, powered_down, sampling, converting},
            {12'd0, oe, pd, s, c}, what);
    endtask

    task automatic finish_run();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        logic [15:0] w;
        logic b;
        tick(4);
        rst_n = 1'b1;
        tick(2);
        cmp_en = 1;
        // R1: reset state with chip select high
        flags("R1", 1'b0, 1'b1, 1'b0, 1'b0, "reset state");

        // DSP frame
        cur_req = "R4";
        fs = 1'b0; cs_n = 1'b0; tick(3);
        flags("R4", 1'b1, 1'b1, 1'b0, 1'b0, "dsp resolved, awaiting frame sync");
        cur_req = "R5";
        conv_result = 10'h2A5;
        dsp_start();
        flags("R5", 1'b1, 1'b0, 1'b1, 1'b0, "sampling after first low fall");
        w = '0;
        read_bits(6, w);
        flags("R5", 1'b1, 1'b0, 1'b0, 1'b1, "converting after sixth rise");
        cur_req = "R10";
        conv_result = 10'h15A;
        read_bits(10, w);
        chk("R3", w, 16'h02A5, "dsp word, zeros then msb first");
        chk("R10", w, 16'h02A5, "late input change ignored");
        cur_req = "R6";
        flags("R6", 1'b1, 1'b1, 1'b0, 1'b0, "auto powerdown at 17th fall");
        sclk = 1'b1; tick(2);
        flags("R6", 1'b0, 1'b1, 1'b0, 1'b0, "three-state at 17th rise");
        sclk = 1'b0; tick(2);
        fs = 1'b1; sc(b);
        flags("R6", 1'b1, 1'b0, 1'b0, 1'b0, "wake on frame sync");

        // Back-to-back frames
        cur_req = "R7";
        fs = 1'b0; sc(b);
        conv_result = 10'h0F0;
        w = '0;
        read_bits(15, w);
        fs = 1'b1; sc(b); w = {w[14:0], b};
        chk("R3", w, 16'h00F0, "word before back-to-back");
        flags("R7", 1'b1, 1'b0, 1'b0, 1'b0, "frame sync on 17th fall, no powerdown");
        fs = 1'b0; sc(b);
        conv_result = 10'h301;
        w = '0;
        read_bits(16, w);
        chk("R7", w, 16'h0301, "back-to-back word");

        // Mid-frame abort
        fs = 1'b1; sc(b);
        fs = 1'b0; sc(b);
        conv_result = 10'h3C0;
        read_bits(9, w);
        fs = 1'b1; sc(b);
        flags("R7", 1'b1, 1'b0, 1'b0, 1'b0, "abort mid frame");
        fs = 1'b0; sc(b);
        conv_result = 10'h1C3;
        w = '0;
        read_bits(16, w);
        chk("R7", w, 16'h01C3, "word after abort");

        // Chip select high
        cur_req = "R1";
        cs_n = 1'b1; tick(2);
        flags("R1", 1'b0, 1'b1, 1'b0, 1'b0, "chip select high");
        chk("R1", {15'd0, dout}, 16'd0, "dout low when off");

        // Mode strap disagreement, both orders, then agreement
        cur_req = "R2";
        fs = 1'b1; cs_n = 1'b0; tick(1);
        fs = 1'b0; tick(2);
        flags("R2", 1'b1, 1'b1, 1'b0, 1'b0, "strap 1 then 0 gives dsp");
        cs_n = 1'b1; tick(2);
        fs = 1'b0; cs_n = 1'b0; tick(1);
        fs = 1'b1; tick(2);
        flags("R2", 1'b1, 1'b1, 1'b0, 1'b0, "strap 0 then 1 gives dsp");
        cs_n = 1'b1; tick(2);
        fs = 1'b1; cs_n = 1'b0; tick(3);
        flags("R2", 1'b1, 1'b0, 1'b0, 1'b0, "strap 1 and 1 gives micro");

        // Micro mode frames
        cur_req = "R8";
        conv_result = 10'h3FF;
        sclk = 1'b1; tick(2);
        flags("R8", 1'b1, 1'b0, 1'b1, 1'b0, "sampling from first rise");
        b = dout;
        sclk = 1'b0; tick(2);
        w = {15'd0, b};
        read_bits(15, w);
        chk("R8", w, 16'h03FF, "micro word");
        flags("R8", 1'b1, 1'b1, 1'b0, 1'b0, "powerdown at 16th fall");
        conv_result = 10'h001;
        fs = 1'b0;
        w = '0;
        read_bits(8, w);
        fs = 1'b1;
        read_bits(8, w);
        chk("R8", w, 16'h0001, "frame sync ignored, wake on 17th rise");

        // Early chip-select rise in micro mode
        cur_req = "R9";
        conv_result = 10'h2CC;
        read_bits(8, w);
        cs_n = 1'b1; tick(2);
        flags("R9", 1'b0, 1'b1, 1'b0, 1'b0, "early chip select rise");
        cs_n = 1'b0; tick(3);
        conv_result = 10'h133;
        w = '0;
        read_bits(16, w);
        chk("R9", w, 16'h0133, "fresh frame after early end");

        cs_n = 1'b1; tick(3);
        cmp_en = 0;
        finish_run();
    end
endmodule